// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose read path has no output register. Address, write data, chip selects, the two address-load strobes, the advance input and the write controls are all sampled on the rising clock edge. The output enable and the sleep input act without waiting for a clock. Read data for the address held in the address register appears on `rdata` during the cycle that follows the edge that registered it. A four-beat read burst therefore takes 2-1-1-1 clocks.

A burst starts on either of two strobes. `ld_rd_n` always starts a read. `ld_rw_n` starts an access that obeys the write controls. After a load, the two low address bits come from a 2-bit beat counter. The counter steps only on non-strobe cycles where `adv_n` is low. It runs in linear or interleaved order, as chosen by `lin_order`. Bursting is optional: a new address may be loaded on every edge.

Writes use byte lanes. A global-write input writes every lane. Sleep freezes the block while keeping the memory contents.

Top module: `fts_sram`

## Requirements
- R1: An edge with `ld_rd_n` low and all three selects low loads `addr` into the address register and performs a read, whatever the write controls are. The read data shows in the following cycle. `ld_rd_n` takes priority when both strobes are low.
- R2: An edge with `ld_rw_n` low, `ld_rd_n` high and all selects low loads `addr`. At that edge it writes the enabled lanes of `wdata` to `addr`, or it reads when no lane is enabled.
- R3: A strobe edge with any of `sel1_n`, `sel2_n`, `sel3_n` high is not accepted: nothing is written, `rvalid` is low afterwards, and the block stays deselected until the next accepted load.
- R4: On a non-strobe edge of an active burst, the beat counter steps only when `adv_n` is low. With `adv_n` high, the same location is accessed again. The write controls apply to continuation edges.
- R5: With `lin_order`=1, beat n (n=0 at load) addresses low bits (start+n) mod 4. Address bits above bit 1 keep their loaded value for the whole burst.
- R6: With `lin_order`=0, beat n addresses low bits start XOR (n mod 4).
- R7: Reads are flow-through: after the edge that registers a read address A, `rdata` equals the word at A and `rvalid` is 1 before the next edge.
- R8: With `all_wen_n` high and `lane_wen_n` low, lane i (bits 8i+7 to 8i) is written exactly when `lane_n[i]` is low. The other lanes keep their contents.
- R9: With `all_wen_n` low, all four lanes are written, whatever `lane_wen_n` and `lane_n` are.
- R10: `oe_n` high forces `rvalid` to 0 and `rdata` to zero at once, with no clock edge. Lowering it restores the pending read.
- R11: While `sleep` is high, `rvalid` is 0 at once. Clock edges change neither the address, the burst state nor the memory. On waking, the pending read reappears unchanged.
- R12: After reset, `rvalid` is 0 until an accepted read.
- R13: Loads on consecutive edges each return their own word in the cycle that follows, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Word address sampled on loads |
| wdata | input | NB*8 | Write data |
| rdata | output | NB*8 | Flow-through read data, zero when not valid |
| rvalid | output | 1 | Read data valid |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2_n | input | 1 | Chip select 2, active low |
| sel3_n | input | 1 | Chip select 3, active low |
| ld_rd_n | input | 1 | Address load strobe, read only, active low |
| ld_rw_n | input | 1 | Address load strobe, honours writes, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_n | input | NB | Per-lane write selects, active low |
| lane_wen_n | input | 1 | Byte-lane write enable, active low |
| all_wen_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |

## Verification
Two functions can fall in the same cycle. One is the sleep or output-enable gating, which acts without a clock. The other is the clocked load-and-write path. The bench raises `sleep` while a read is pending and then presents a full write with a load strobe on several edges. It judges the overlap at the ports. `rvalid` must drop before any edge. After waking, the earlier read must return unchanged, and the targeted word must still hold its old value. The same overlap is provoked between a read-only load and active global-write controls, and there the read must win and memory must be untouched.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    CYC_NONE    = 2'd0,
    CYC_LOAD_RD = 2'd1,
    CYC_LOAD_RW = 2'd2,
    CYC_CONT    = 2'd3
  } cyc_kind_e;

  // Low address bits for a beat of a burst
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] beat,
                                              input logic       linear);
    return linear ? 2'(start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] start,
  input  logic       linear,
  output logic [1:0] cur_low,
  output logic [1:0] nxt_low
);

  logic [1:0] base_q, beat_q;
  logic [1:0] base_d, beat_d;

  always_comb begin
    base_d = load ? start : base_q;
    if (load)      beat_d = 2'd0;
    else if (step) beat_d = 2'(beat_q + 2'd1);
    else           beat_d = beat_q;
  end

  assign cur_low = burst_offset(base_q, beat_q, linear);
  assign nxt_low = burst_offset(base_d, beat_d, linear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 2'd0;
      beat_q <= 2'd0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [2:0]        sel_n,
  input  logic              ld_rd_n,
  input  logic              ld_rw_n,
  input  logic              adv_n,
  input  logic              all_wen_n,
  input  logic              lane_wen_n,
  input  logic [NB-1:0]     lane_n,
  input  logic [ADDR_W-3:0] addr_hi,
  output logic              load_ev,
  output logic              step_ev,
  output logic [NB-1:0]     wr_lanes,
  output logic [ADDR_W-3:0] hi_q,
  output logic              rd_q
);

  function automatic logic [NB-1:0] lane_mask(input logic          glob_n,
                                              input logic          bw_n,
                                              input logic [NB-1:0] sel);
    if (!glob_n)    return '1;
    else if (!bw_n) return ~sel;
    else            return '0;
  endfunction

  logic      chip_ok, awake, any_strobe, act_q, desel_ev;
  cyc_kind_e kind;

  assign chip_ok    = (sel_n == 3'b000);
  assign awake      = !sleep;
  assign any_strobe = !ld_rd_n || !ld_rw_n;

  always_comb begin
    kind = CYC_NONE;
    if (awake) begin
      if (!ld_rd_n && chip_ok)      kind = CYC_LOAD_RD;
      else if (!ld_rw_n && chip_ok) kind = CYC_LOAD_RW;
      else if (!any_strobe && act_q) kind = CYC_CONT;
    end
  end

  assign desel_ev = awake && any_strobe && !chip_ok;
  assign load_ev  = (kind == CYC_LOAD_RD) || (kind == CYC_LOAD_RW);
  assign step_ev  = (kind == CYC_CONT) && !adv_n;
  assign wr_lanes = ((kind == CYC_LOAD_RW) || (kind == CYC_CONT))
                    ? lane_mask(all_wen_n, lane_wen_n, lane_n) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      hi_q  <= '0;
      rd_q  <= 1'b0;
    end else if (awake) begin
      if (load_ev)       act_q <= 1'b1;
      else if (desel_ev) act_q <= 1'b0;
      if (load_ev) hi_q <= addr_hi;
      rd_q <= (kind == CYC_LOAD_RD) ||
              (((kind == CYC_LOAD_RW) || (kind == CYC_CONT)) && (wr_lanes == '0));
    end
  end

endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int ADDR_W = 8,
  parameter int NB     = 4,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic [NB-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [NB*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [NB*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end

endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int ADDR_W = 8,
  parameter int NB     = 4,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NB*LANE_W-1:0] wdata,
  output logic [NB*LANE_W-1:0] rdata,
  output logic                 rvalid,
  input  logic                 sel1_n,
  input  logic                 sel2_n,
  input  logic                 sel3_n,
  input  logic                 ld_rd_n,
  input  logic                 ld_rw_n,
  input  logic                 adv_n,
  input  logic [NB-1:0]        lane_n,
  input  logic                 lane_wen_n,
  input  logic                 all_wen_n,
  input  logic                 oe_n,
  input  logic                 sleep,
  input  logic                 lin_order
);

  localparam int HI_W = ADDR_W - 2;

  logic              load_ev, step_ev, rd_q;
  logic [NB-1:0]     wr_lanes;
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        cur_low, nxt_low;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [NB*LANE_W-1:0] arr_q;

  fts_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .sel_n      ({sel3_n, sel2_n, sel1_n}),
    .ld_rd_n    (ld_rd_n),
    .ld_rw_n    (ld_rw_n),
    .adv_n      (adv_n),
    .all_wen_n  (all_wen_n),
    .lane_wen_n (lane_wen_n),
    .lane_n     (lane_n),
    .addr_hi    (addr[ADDR_W-1:2]),
    .load_ev    (load_ev),
    .step_ev    (step_ev),
    .wr_lanes   (wr_lanes),
    .hi_q       (hi_q),
    .rd_q       (rd_q)
  );

  fts_burst_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ev),
    .step    (step_ev),
    .start   (addr[1:0]),
    .linear  (lin_order),
    .cur_low (cur_low),
    .nxt_low (nxt_low)
  );

  assign cur_addr = {hi_q, cur_low};
  assign nxt_addr = {(load_ev ? addr[ADDR_W-1:2] : hi_q), nxt_low};

  fts_array #(.ADDR_W(ADDR_W), .NB(NB), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .waddr    (nxt_addr),
    .wdata    (wdata),
    .raddr    (cur_addr),
    .rdata    (arr_q)
  );

  assign rvalid = rd_q && !oe_n && !sleep;
  assign rdata  = rvalid ? arr_q : '0;

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int NB     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              oe_n,
  input logic              ld_rd_n,
  input logic              sel1_n,
  input logic              sel2_n,
  input logic              sel3_n,
  input logic              lin_order,
  input logic              rvalid,
  input logic              load_ev,
  input logic              step_ev,
  input logic [NB-1:0]     wr_lanes,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] addr
);

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cur_addr));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rvalid && wr_lanes == '0));

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid);

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (cur_addr == $past(addr)));

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(cur_addr[ADDR_W-1:2]));

  // R4
  no_adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !step_ev) |=> ($stable(cur_addr) || !$stable(lin_order)));

  // R1
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !ld_rd_n) |-> (wr_lanes == '0));

  // R3
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_n || sel2_n || sel3_n) |-> !load_ev);

endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W), .NB(NB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep     (sleep),
  .oe_n      (oe_n),
  .ld_rd_n   (ld_rd_n),
  .sel1_n    (sel1_n),
  .sel2_n    (sel2_n),
  .sel3_n    (sel3_n),
  .lin_order (lin_order),
  .rvalid    (rvalid),
  .load_ev   (load_ev),
  .step_ev   (step_ev),
  .wr_lanes  (wr_lanes),
  .cur_addr  (cur_addr),
  .addr      (addr)
);

// File: tb/fts_sram_tb.sv
module fts_sram_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        sel1_n = 1'b0, sel2_n = 1'b0, sel3_n = 1'b0;
  logic        ld_rd_n = 1'b1, ld_rw_n = 1'b1, adv_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic        lane_wen_n = 1'b1, all_wen_n = 1'b1;
  logic        oe_n = 1'b0, sleep = 1'b0, lin_order = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] ref_mem [256];

  always #2.5 clk = ~clk;

  fts_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid), .sel1_n(sel1_n), .sel2_n(sel2_n), .sel3_n(sel3_n),
    .ld_rd_n(ld_rd_n), .ld_rw_n(ld_rw_n), .adv_n(adv_n), .lane_n(lane_n),
    .lane_wen_n(lane_wen_n), .all_wen_n(all_wen_n), .oe_n(oe_n),
    .sleep(sleep), .lin_order(lin_order)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ld_rd_n = 1'b1; ld_rw_n = 1'b1; adv_n = 1'b1;
    lane_n = 4'hF; lane_wen_n = 1'b1; all_wen_n = 1'b1;
    sel1_n = 1'b0; sel2_n = 1'b0; sel3_n = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    ld_rw_n = 1'b0; addr = a; wdata = d; all_wen_n = 1'b0;
    step();
    idle();
    ref_mem[a] = d;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    ld_rd_n = 1'b0; addr = a;
    step();
    idle();
    chk({req, " rvalid"}, 32'(rvalid), 32'd1);
    chk({req, " rdata"}, rdata, exp);
  endtask

  task automatic t_reset();
    step();
    chk("R12 reset rvalid", 32'(rvalid), 32'd0);
  endtask

  task automatic t_preload();
    for (int i = 0; i < 4; i++) wr_word(8'h10 + 8'(i), 32'hA000_0000 + 32'(i));
    wr_word(8'h20, 32'h5555_0020);
    wr_word(8'h30, 32'h3333_0030);
    chk("R2 rvalid low after write", 32'(rvalid), 32'd0);
    rd_check("R2 R7 readback", 8'h30, 32'h3333_0030);
  endtask

  task automatic t_b2b();
    logic [7:0] seq [3] = '{8'h10, 8'h13, 8'h20};
    for (int i = 0; i < 3; i++) begin
      ld_rd_n = 1'b0; addr = seq[i];
      step();
      chk("R13 b2b rvalid", 32'(rvalid), 32'd1);
      chk("R13 b2b rdata", rdata, ref_mem[seq[i]]);
    end
    idle();
  endtask

  task automatic t_burst(input logic lin);
    lin_order = lin;
    ld_rd_n = 1'b0; addr = 8'h11;
    step();
    idle();
    chk(lin ? "R5 beat0" : "R6 beat0", rdata, ref_mem[8'h11]);
    adv_n = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      logic [1:0] lo;
      step();
      lo = lin ? 2'((1 + n) % 4) : 2'(1 ^ (n % 4));
      chk(lin ? "R5 linear beat" : "R6 interleaved beat", rdata, ref_mem[{6'h04, lo}]);
    end
    idle();
    lin_order = 1'b1;
  endtask

  task automatic t_hold();
    ld_rd_n = 1'b0; addr = 8'h12;
    step();
    idle();
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R4 hold same addr", rdata, ref_mem[8'h12]);
    end
    adv_n = 1'b0;
    step();
    idle();
    chk("R4 advance", rdata, ref_mem[8'h13]);
  endtask

  task automatic t_rd_strobe_write_ignored();
    ld_rd_n = 1'b0; addr = 8'h20; all_wen_n = 1'b0; lane_wen_n = 1'b0;
    lane_n = 4'h0; wdata = 32'hDEAD_BEEF;
    step();
    idle();
    chk("R1 read wins rvalid", 32'(rvalid), 32'd1);
    chk("R1 read wins rdata", rdata, ref_mem[8'h20]);
    ld_rd_n = 1'b0; ld_rw_n = 1'b0; addr = 8'h20; all_wen_n = 1'b0;
    wdata = 32'hBAD0_BAD0;
    step();
    idle();
    chk("R1 both strobes read", rdata, ref_mem[8'h20]);
    rd_check("R1 memory untouched", 8'h20, ref_mem[8'h20]);
  endtask

  task automatic t_sel();
    for (int i = 0; i < 3; i++) begin
      ld_rw_n = 1'b0; addr = 8'h30; all_wen_n = 1'b0; wdata = 32'hFFFF_0000;
      sel1_n = (i == 0); sel2_n = (i == 1); sel3_n = (i == 2);
      step();
      idle();
      chk("R3 deselect rvalid", 32'(rvalid), 32'd0);
      step();
      chk("R3 stays deselected", 32'(rvalid), 32'd0);
      rd_check("R3 no write", 8'h30, ref_mem[8'h30]);
    end
  endtask

  task automatic t_lanes();
    wr_word(8'h20, 32'h1122_3344);
    ld_rw_n = 1'b0; addr = 8'h20; lane_wen_n = 1'b0; lane_n = 4'b1010;
    wdata = 32'hAABB_CCDD;
    step();
    idle();
    ref_mem[8'h20] = 32'h11BB_33DD;
    rd_check("R8 byte lanes", 8'h20, 32'h11BB_33DD);
    ld_rw_n = 1'b0; addr = 8'h20; lane_wen_n = 1'b1; lane_n = 4'hF;
    wdata = 32'h0000_0000;
    step();
    idle();
    rd_check("R8 no enable no write", 8'h20, 32'h11BB_33DD);
  endtask

  task automatic t_global();
    ld_rw_n = 1'b0; addr = 8'h21; all_wen_n = 1'b0; lane_wen_n = 1'b1;
    lane_n = 4'hF; wdata = 32'hCAFE_F00D;
    step();
    idle();
    rd_check("R9 global no lanes", 8'h21, 32'hCAFE_F00D);
    ld_rw_n = 1'b0; addr = 8'h21; all_wen_n = 1'b0; lane_wen_n = 1'b0;
    lane_n = 4'b1110; wdata = 32'h0102_0304;
    step();
    idle();
    ref_mem[8'h21] = 32'h0102_0304;
    rd_check("R9 global overrides lanes", 8'h21, 32'h0102_0304);
  endtask

  task automatic t_burst_write();
    lin_order = 1'b1;
    ld_rw_n = 1'b0; addr = 8'h40; all_wen_n = 1'b0; wdata = 32'hB000_0000;
    step();
    ld_rw_n = 1'b1; adv_n = 1'b0;
    for (int n = 1; n < 4; n++) begin
      wdata = 32'hB000_0000 + 32'(n);
      step();
    end
    idle();
    for (int n = 0; n < 4; n++) begin
      ref_mem[8'h40 + 8'(n)] = 32'hB000_0000 + 32'(n);
      rd_check("R4 R2 burst write", 8'h40 + 8'(n), 32'hB000_0000 + 32'(n));
    end
  endtask

  task automatic t_oe();
    ld_rd_n = 1'b0; addr = 8'h10;
    step();
    idle();
    chk("R10 before", 32'(rvalid), 32'd1);
    oe_n = 1'b1;
    #1;
    chk("R10 oe async rvalid", 32'(rvalid), 32'd0);
    chk("R10 oe async rdata", rdata, 32'd0);
    oe_n = 1'b0;
    #1;
    chk("R10 oe restore", rdata, ref_mem[8'h10]);
  endtask

  task automatic t_sleep();
    ld_rd_n = 1'b0; addr = 8'h10;
    step();
    idle();
    sleep = 1'b1;
    #1;
    chk("R11 sleep async rvalid", 32'(rvalid), 32'd0);
    ld_rw_n = 1'b0; addr = 8'h13; all_wen_n = 1'b0; wdata = 32'h0BAD_0BAD;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 asleep rvalid", 32'(rvalid), 32'd0);
    end
    idle();
    sleep = 1'b0;
    #1;
    chk("R11 wake rvalid", 32'(rvalid), 32'd1);
    chk("R11 wake same read", rdata, ref_mem[8'h10]);
    rd_check("R11 contents kept", 8'h13, ref_mem[8'h13]);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_preload();
    t_b2b();
    t_burst(1'b1);
    t_burst(1'b0);
    t_hold();
    t_rd_strobe_write_ignored();
    t_sel();
    t_lanes();
    t_global();
    t_burst_write();
    t_oe();
    t_sleep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule